// File: doc/BRIEF.md
# Next Program Counter and Branch Condition Unit

This unit decides where a simple sequential processor fetches next after each instruction. It receives the decoded instruction class and function code, the three condition flags (zero, sign, overflow), the absolute destination constant carried by jumps and calls, the fall-through address of the following instruction, and the word just read from the top of the stack. It produces the next program counter, a flag saying that control flow left the fall-through path, the return address to be written for a call, and the stack control for the surrounding datapath: push or pop, and a signed stack-pointer adjustment of one word.

The unit also owns the program counter register. The register starts at address zero, advances on every cycle in which `step_i` is high, and freezes once a halt instruction has been executed. Jump and call targets are absolute addresses, never offsets from the current PC. The stack grows toward lower addresses, so a push moves the pointer down by one word and a pop moves it up by one word.

Top module: `nxpc_unit`

## Requirements
- R1: After synchronous reset, `pc_o` is 0 and `halted_o` is 0.
- R2: With `icode_i` = 7 (jump), the function code selects the condition: 0 always, 1 less-or-equal ((SF xor OF) or ZF), 2 less (SF xor OF), 3 equal (ZF), 4 not-equal (not ZF), 5 greater-or-equal (not (SF xor OF)), 6 greater (not (SF xor OF) and not ZF). When the condition holds, `taken_o` is 1 and `next_pc_o` equals `dest_i`.
- R3: A jump whose condition is false, or whose function code is 7 to 15, gives `taken_o` = 0 and `next_pc_o` = `fall_pc_i`.
- R4: With `icode_i` = 8 (call), `next_pc_o` = `dest_i`, `taken_o` = 1, `ret_addr_o` = `fall_pc_i`, `push_o` = 1 and `sp_adj_o` = -4.
- R5: With `icode_i` = 9 (return), `next_pc_o` = `pop_val_i`, `taken_o` = 1, `pop_o` = 1 and `sp_adj_o` = +4.
- R6: With `icode_i` = 10 (register push) `push_o` = 1 and `sp_adj_o` = -4; with `icode_i` = 11 (register pop) `pop_o` = 1 and `sp_adj_o` = +4; both continue at `fall_pc_i` with `taken_o` = 0.
- R7: Every other instruction class except halt (codes 0, 2 to 6, 12 to 15) gives `next_pc_o` = `fall_pc_i`, `taken_o` = 0, no push, no pop, `sp_adj_o` = 0 and `ret_addr_o` = 0. `ret_addr_o` is 0 for every class other than call.
- R8: With `icode_i` = 1 (halt), `next_pc_o` equals `pc_o`. A stepped halt sets `halted_o`. While halted, `pc_o` holds its value whatever is applied, `next_pc_o` equals `pc_o`, and `taken_o`, `push_o` and `pop_o` are 0. Only reset clears it.
- R9: `pc_o` takes the value of `next_pc_o` at a rising edge where `step_i` is 1 and the unit is not halted. It holds its value when `step_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Commit the current instruction and advance the PC |
| icode_i | input | 4 | Instruction class code |
| ifun_i | input | 4 | Function code (jump condition selector) |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| dest_i | input | AW | Absolute destination for jump and call |
| fall_pc_i | input | AW | Address of the following instruction |
| pop_val_i | input | AW | Word read from the stack top |
| pc_o | output | AW | Current program counter |
| next_pc_o | output | AW | Selected next program counter |
| taken_o | output | 1 | Control flow left the fall-through path |
| ret_addr_o | output | AW | Return address to push for a call |
| push_o | output | 1 | Stack push requested |
| pop_o | output | 1 | Stack pop requested |
| sp_adj_o | output | AW | Signed stack-pointer adjustment |
| halted_o | output | 1 | Execution stopped by halt |

## Verification
The hardest state to reach is the halted state combined with more control flow. The register must then ignore a taken jump that would otherwise move it, and every stack request must stay low. The stimulus reaches it by first moving the PC to a nonzero address through a stepped jump, then stepping a halt, then applying a taken jump, a call and a return with `step_i` high. It checks that `pc_o` still holds the halt address, and finally checks that reset alone restores address zero. The full condition table is covered by sweeping all eight flag combinations against function codes 0 through 7.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    typedef enum logic [3:0] {
        IC_NOP   = 4'h0,
        IC_HALT  = 4'h1,
        IC_RRMOV = 4'h2,
        IC_IRMOV = 4'h3,
        IC_RMMOV = 4'h4,
        IC_MRMOV = 4'h5,
        IC_ALU   = 4'h6,
        IC_JXX   = 4'h7,
        IC_CALL  = 4'h8,
        IC_RET   = 4'h9,
        IC_PUSH  = 4'hA,
        IC_POP   = 4'hB
    } icode_e;

    typedef enum logic [2:0] {
        JC_ALWAYS = 3'd0,
        JC_LE     = 3'd1,
        JC_LT     = 3'd2,
        JC_EQ     = 3'd3,
        JC_NE     = 3'd4,
        JC_GE     = 3'd5,
        JC_GT     = 3'd6
    } jcond_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_PUSH = 2'd1,
        SK_POP  = 2'd2
    } stk_op_e;

    typedef enum logic [1:0] {
        SRC_FALL = 2'd0,
        SRC_DEST = 2'd1,
        SRC_POP  = 2'd2,
        SRC_HOLD = 2'd3
    } pc_src_e;

    function automatic logic cond_holds(input logic [3:0] fn, input flags_t f);
        logic lt;
        lt = f.sf ^ f.of;
        if (fn[3])
            return 1'b0;
        case (jcond_e'(fn[2:0]))
            JC_ALWAYS: return 1'b1;
            JC_LE:     return lt | f.zf;
            JC_LT:     return lt;
            JC_EQ:     return f.zf;
            JC_NE:     return ~f.zf;
            JC_GE:     return ~lt;
            JC_GT:     return ~lt & ~f.zf;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/nxpc_cond.sv
module nxpc_cond
    import nxpc_pkg::*;
(
    input  logic [3:0] ifun_i,
    input  flags_t     flags_i,
    output logic       met_o
);
    always_comb begin
        met_o = cond_holds(ifun_i, flags_i);
    end
endmodule

// File: rtl/nxpc_select.sv
module nxpc_select
    import nxpc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int STK_BYTES = 4
) (
    input  logic [3:0]    icode_i,
    input  logic          cond_i,
    input  logic          halted_i,
    output pc_src_e       src_o,
    output stk_op_e       stk_o,
    output logic          is_halt_o,
    output logic          is_call_o,
    output logic [AW-1:0] adj_o
);
    localparam logic [AW-1:0] ADJ_UP   = AW'(STK_BYTES);
    localparam logic [AW-1:0] ADJ_DOWN = ~ADJ_UP + AW'(1);

    always_comb begin
        src_o     = SRC_FALL;
        stk_o     = SK_NONE;
        is_halt_o = 1'b0;
        is_call_o = 1'b0;
        if (halted_i) begin
            src_o = SRC_HOLD;
        end else begin
            case (icode_e'(icode_i))
                IC_HALT: begin
                    src_o     = SRC_HOLD;
                    is_halt_o = 1'b1;
                end
                IC_JXX:  src_o = cond_i ? SRC_DEST : SRC_FALL;
                IC_CALL: begin
                    src_o     = SRC_DEST;
                    stk_o     = SK_PUSH;
                    is_call_o = 1'b1;
                end
                IC_RET: begin
                    src_o = SRC_POP;
                    stk_o = SK_POP;
                end
                IC_PUSH: stk_o = SK_PUSH;
                IC_POP:  stk_o = SK_POP;
                default: src_o = SRC_FALL;
            endcase
        end
    end

    always_comb begin
        case (stk_o)
            SK_PUSH: adj_o = ADJ_DOWN;
            SK_POP:  adj_o = ADJ_UP;
            default: adj_o = '0;
        endcase
    end
endmodule

// File: rtl/nxpc_pc_reg.sv
module nxpc_pc_reg #(
    parameter int AW = 32,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    input  logic          halt_i,
    input  logic [AW-1:0] next_i,
    output logic [AW-1:0] pc_o,
    output logic          halted_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_o     <= RESET_PC;
            halted_o <= 1'b0;
        end else if (step_i && !halted_o) begin
            pc_o <= next_i;
            if (halt_i)
                halted_o <= 1'b1;
        end
    end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int STK_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    input  logic [3:0]    icode_i,
    input  logic [3:0]    ifun_i,
    input  logic          zf_i,
    input  logic          sf_i,
    input  logic          of_i,
    input  logic [AW-1:0] dest_i,
    input  logic [AW-1:0] fall_pc_i,
    input  logic [AW-1:0] pop_val_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] next_pc_o,
    output logic          taken_o,
    output logic [AW-1:0] ret_addr_o,
    output logic          push_o,
    output logic          pop_o,
    output logic [AW-1:0] sp_adj_o,
    output logic          halted_o
);
    flags_t  flags;
    logic    cond_met;
    pc_src_e src;
    stk_op_e stk;
    logic    is_halt;
    logic    is_call;

    assign flags = '{zf: zf_i, sf: sf_i, of: of_i};

    nxpc_cond u_cond (
        .ifun_i  (ifun_i),
        .flags_i (flags),
        .met_o   (cond_met)
    );

    nxpc_select #(.AW(AW), .STK_BYTES(STK_BYTES)) u_sel (
        .icode_i   (icode_i),
        .cond_i    (cond_met),
        .halted_i  (halted_o),
        .src_o     (src),
        .stk_o     (stk),
        .is_halt_o (is_halt),
        .is_call_o (is_call),
        .adj_o     (sp_adj_o)
    );

    always_comb begin
        case (src)
            SRC_DEST: next_pc_o = dest_i;
            SRC_POP:  next_pc_o = pop_val_i;
            SRC_HOLD: next_pc_o = pc_o;
            default:  next_pc_o = fall_pc_i;
        endcase
    end

    assign taken_o    = (src == SRC_DEST) || (src == SRC_POP);
    assign push_o     = (stk == SK_PUSH);
    assign pop_o      = (stk == SK_POP);
    assign ret_addr_o = is_call ? fall_pc_i : '0;

    nxpc_pc_reg #(.AW(AW)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step_i),
        .halt_i   (is_halt),
        .next_i   (next_pc_o),
        .pc_o     (pc_o),
        .halted_o (halted_o)
    );
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          step_i,
    input logic [3:0]    icode_i,
    input logic [3:0]    ifun_i,
    input logic [AW-1:0] dest_i,
    input logic [AW-1:0] fall_pc_i,
    input logic [AW-1:0] pop_val_i,
    input logic [AW-1:0] pc_o,
    input logic [AW-1:0] next_pc_o,
    input logic          taken_o,
    input logic [AW-1:0] ret_addr_o,
    input logic          push_o,
    input logic          pop_o,
    input logic          halted_o
);
    // R9
    pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !halted_o) |=> (pc_o == $past(next_pc_o)));

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_i) |=> $stable(pc_o));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && $stable(pc_o)));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |-> (!taken_o && !push_o && !pop_o && next_pc_o == pc_o));

    // R4
    call_target_chk: assert property (@(posedge clk) disable iff (rst)
        (icode_i == 4'h8 && !halted_o) |->
            (push_o && taken_o && next_pc_o == dest_i && ret_addr_o == fall_pc_i));

    // R5
    ret_target_chk: assert property (@(posedge clk) disable iff (rst)
        (icode_i == 4'h9 && !halted_o) |-> (pop_o && taken_o && next_pc_o == pop_val_i));

    // R3
    bad_fun_chk: assert property (@(posedge clk) disable iff (rst)
        (icode_i == 4'h7 && ifun_i > 4'd6 && !halted_o) |->
            (!taken_o && next_pc_o == fall_pc_i));

    // R6
    stk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push_o, pop_o}));
endmodule

bind nxpc_unit nxpc_unit_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .icode_i    (icode_i),
    .ifun_i     (ifun_i),
    .dest_i     (dest_i),
    .fall_pc_i  (fall_pc_i),
    .pop_val_i  (pop_val_i),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .ret_addr_o (ret_addr_o),
    .push_o     (push_o),
    .pop_o      (pop_o),
    .halted_o   (halted_o)
);

// File: tb/nxpc_unit_tb_top.sv
`timescale 1ns/1ps
module nxpc_unit_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          step_i;
    logic [3:0]    icode_i, ifun_i;
    logic          zf_i, sf_i, of_i;
    logic [AW-1:0] dest_i, fall_pc_i, pop_val_i;
    logic [AW-1:0] pc_o, next_pc_o, ret_addr_o, sp_adj_o;
    logic          taken_o, push_o, pop_o, halted_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nxpc_unit #(.AW(AW)) dut_i (.*);

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic stp, input logic [3:0] ic, input logic [3:0] fn,
                         input logic [2:0] zso, input logic [AW-1:0] d,
                         input logic [AW-1:0] f, input logic [AW-1:0] p);
        @(negedge clk);
        step_i = stp; icode_i = ic; ifun_i = fn;
        {zf_i, sf_i, of_i} = zso;
        dest_i = d; fall_pc_i = f; pop_val_i = p;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic expect_cond(input int fn, input logic z, input logic s, input logic o);
        case (fn)
            0: return 1'b1;
            1: return (s != o) || z;
            2: return (s != o);
            3: return z;
            4: return !z;
            5: return (s == o);
            6: return (s == o) && !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 pc", pc_o, 0);
        chk("R1 halted", {31'b0, halted_o}, 0);
    endtask

    task automatic t_cond_table();
        for (int fn = 0; fn < 8; fn++) begin
            for (int fl = 0; fl < 8; fl++) begin
                logic e;
                e = expect_cond(fn, fl[2], fl[1], fl[0]);
                drive(1'b0, 4'h7, 4'(fn), 3'(fl), 32'hA000_0000 + fn, 32'h0000_0040, 32'h0);
                chk(e ? "R2 taken" : "R3 taken", {31'b0, taken_o}, {31'b0, e});
                chk(e ? "R2 next" : "R3 next", next_pc_o, e ? 32'hA000_0000 + fn : 32'h40);
            end
        end
        drive(1'b0, 4'h7, 4'hF, 3'b000, 32'h1234, 32'h50, 32'h0);
        chk("R3 fn15 next", next_pc_o, 32'h50);
        chk("R3 fn15 taken", {31'b0, taken_o}, 0);
    endtask

    task automatic t_call_ret();
        drive(1'b0, 4'h8, 4'h0, 3'b000, 32'h0000_0300, 32'h0000_0015, 32'h77);
        chk("R4 next", next_pc_o, 32'h300);
        chk("R4 ret_addr", ret_addr_o, 32'h15);
        chk("R4 push/pop/taken", {29'b0, push_o, pop_o, taken_o}, 32'b101);
        chk("R4 adj", sp_adj_o, 32'hFFFF_FFFC);
        drive(1'b0, 4'h9, 4'h0, 3'b000, 32'h0000_0300, 32'h0000_0015, 32'h0000_0BEE);
        chk("R5 next", next_pc_o, 32'hBEE);
        chk("R5 push/pop/taken", {29'b0, push_o, pop_o, taken_o}, 32'b011);
        chk("R5 adj", sp_adj_o, 32'd4);
        chk("R7 ret_addr on ret", ret_addr_o, 0);
    endtask

    task automatic t_push_pop();
        drive(1'b0, 4'hA, 4'h0, 3'b100, 32'h900, 32'h62, 32'h11);
        chk("R6 push next", next_pc_o, 32'h62);
        chk("R6 push flags", {29'b0, push_o, pop_o, taken_o}, 32'b100);
        chk("R6 push adj", sp_adj_o, 32'hFFFF_FFFC);
        drive(1'b0, 4'hB, 4'h0, 3'b100, 32'h900, 32'h64, 32'h11);
        chk("R6 pop next", next_pc_o, 32'h64);
        chk("R6 pop flags", {29'b0, push_o, pop_o, taken_o}, 32'b010);
        chk("R6 pop adj", sp_adj_o, 32'd4);
    endtask

    task automatic t_other();
        logic [3:0] codes [8] = '{4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hC, 4'hF};
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, codes[i], 4'h0, 3'b111, 32'hDEAD, 32'h100 + i, 32'hBEEF);
            chk("R7 next", next_pc_o, 32'h100 + i);
            chk("R7 quiet", {29'b0, push_o, pop_o, taken_o}, 0);
            chk("R7 adj", sp_adj_o, 0);
            chk("R7 ret_addr", ret_addr_o, 0);
        end
    endtask

    task automatic t_step();
        drive(1'b0, 4'h7, 4'h0, 3'b000, 32'h0000_0200, 32'h8, 32'h0);
        @(negedge clk); #1;
        chk("R9 hold without step", pc_o, 0);
        drive(1'b1, 4'h7, 4'h0, 3'b000, 32'h0000_0200, 32'h8, 32'h0);
        @(negedge clk); #1;
        chk("R9 jump committed", pc_o, 32'h200);
        drive(1'b1, 4'h6, 4'h0, 3'b000, 32'h0, 32'h202, 32'h0);
        @(negedge clk); #1;
        chk("R9 fall committed", pc_o, 32'h202);
        step_i = 1'b0;
    endtask

    task automatic t_halt();
        drive(1'b1, 4'h1, 4'h0, 3'b000, 32'h500, 32'h203, 32'h0);
        chk("R8 halt next equals pc", next_pc_o, 32'h202);
        @(negedge clk); #1;
        chk("R8 pc stays", pc_o, 32'h202);
        chk("R8 halted", {31'b0, halted_o}, 1);
        drive(1'b1, 4'h7, 4'h0, 3'b000, 32'h500, 32'h208, 32'h0);
        chk("R8 halted quiet", {29'b0, push_o, pop_o, taken_o}, 0);
        drive(1'b1, 4'h8, 4'h0, 3'b000, 32'h600, 32'h208, 32'h0);
        chk("R8 halted no push", {31'b0, push_o}, 0);
        drive(1'b1, 4'h9, 4'h0, 3'b000, 32'h600, 32'h208, 32'h700);
        @(negedge clk); #1;
        chk("R8 pc frozen", pc_o, 32'h202);
        chk("R8 next pinned", next_pc_o, 32'h202);
        step_i = 1'b0;
        do_reset(); #1;
        chk("R1 reset clears halt", {31'b0, halted_o}, 0);
        chk("R1 reset pc", pc_o, 0);
    endtask

    initial begin
        rst = 1'b1; step_i = 1'b0; icode_i = 4'h0; ifun_i = 4'h0;
        zf_i = 1'b0; sf_i = 1'b0; of_i = 1'b0;
        dest_i = '0; fall_pc_i = '0; pop_val_i = '0;
        t_reset();
        t_cond_table();
        t_call_ret();
        t_push_pop();
        t_other();
        t_step();
        t_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule